// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Signed Overflow Flag

This block is the combinational integer ALU of a small RISC datapath. It takes two operands and a 4-bit operation code, and it returns a result word with three flags. The zero flag shows that every result bit is clear. The carry flag is the adder's top carry. The overflow flag reports signed overflow. The block supports addition, subtraction, four bitwise logic functions and signed and unsigned less-than compares.

A single adder serves every arithmetic operation. To subtract, the adder receives the inverted second operand and a carry-in of one. Signed overflow is the carry entering the top bit XOR the carry leaving it. The block reports overflow only for the signed add and subtract codes; every other code, including the unsigned forms that share the same adder, leaves the flag low. The block only raises the flag. Any trap belongs to the pipeline around it.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 (signed add) and code 1 (unsigned add) return `a + b` modulo 2^32, and `cout` is the carry out of bit 31 of that sum.
- R2: Code 2 (signed subtract) and code 3 (unsigned subtract) return `a - b` modulo 2^32, formed as `a + ~b + 1`, so `cout` is 1 exactly when `a >= b` read as unsigned numbers.
- R3: For codes 0 and 2, `ovf` is 1 exactly when the signed result does not fit in 32 bits, which is the carry into bit 31 XOR the carry out of bit 31.
- R4: Adding two operands of opposite sign with code 0, or subtracting two operands of the same sign with code 2, never sets `ovf`.
- R5: Codes 1, 3, 8 and 9 never set `ovf`, even for operands where codes 0 or 2 would set it, and their result and `cout` follow R1 (code 1) or R2 (codes 3, 8 and 9).
- R6: Codes 4 (AND), 5 (OR), 6 (NOR) and 7 (XOR) apply their function bit by bit across all 32 bits, with `cout` and `ovf` at 0.
- R7: Code 8 (signed less-than) returns 1 in bit 0 when `a < b` as two's-complement numbers, else 0, and this holds even when the difference overflows. Bits 31 to 1 are 0.
- R8: Code 9 (unsigned less-than) returns 1 in bit 0 when the subtraction produces no carry out, which is when `a < b` unsigned, else 0. Bits 31 to 1 are 0.
- R9: `zero` is 1 exactly when all 32 bits of `result` are 0, so a subtraction of equal operands sets it.
- R10: Codes 10 to 15 return a zero result with `cout` and `ovf` at 0, and therefore `zero` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand |
| b | input | 32 | Second operand (subtrahend for subtraction and compares) |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | All result bits are zero |
| cout | output | 1 | Carry out of the adder's top bit (0 for non-adder codes) |
| ovf | output | 1 | Signed overflow for codes 0 and 2 |

## Verification
The zero flag and the overflow flag can both be high for the same operation. Signed add of 0x80000000 to itself wraps to an all-zero word, so carry and overflow are set in the same evaluation. The bench drives that pair and the mirror subtraction case. It predicts all four outputs from wide reference arithmetic and compares them together, so a design that lets one flag mask the other is caught. A second pairing comes from the signed compare whose difference overflows (0x80000000 against 1). There the compare must use the overflow condition internally while the `ovf` port stays low.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int unsigned OP_BITS = 4;

   typedef enum logic [OP_BITS-1:0] {
      OPC_ADD  = 4'd0,
      OPC_ADDU = 4'd1,
      OPC_SUB  = 4'd2,
      OPC_SUBU = 4'd3,
      OPC_AND  = 4'd4,
      OPC_OR   = 4'd5,
      OPC_NOR  = 4'd6,
      OPC_XOR  = 4'd7,
      OPC_SLT  = 4'd8,
      OPC_SLTU = 4'd9
   } alu_opc_e;

   typedef enum logic [2:0] {
      RSEL_NONE  = 3'd0,
      RSEL_SUM   = 3'd1,
      RSEL_BITS  = 3'd2,
      RSEL_LTS   = 3'd3,
      RSEL_LTU   = 3'd4
   } rsel_e;

   typedef enum logic [1:0] {
      BFN_AND = 2'd0,
      BFN_OR  = 2'd1,
      BFN_NOR = 2'd2,
      BFN_XOR = 2'd3
   } bfn_e;

   typedef struct packed {
      logic  invert_b;
      logic  use_adder;
      logic  report_ovf;
      rsel_e rsel;
      bfn_e  bfn;
   } alu_ctrl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
   import int_alu_pkg::*;
(
   input  logic [OP_BITS-1:0] op,
   output alu_ctrl_t          ctrl
);

   always_comb begin
      ctrl = '{invert_b: 1'b0, use_adder: 1'b0, report_ovf: 1'b0,
               rsel: RSEL_NONE, bfn: BFN_AND};
      case (op)
         OPC_ADD: begin
            ctrl.use_adder  = 1'b1;
            ctrl.report_ovf = 1'b1;
            ctrl.rsel       = RSEL_SUM;
         end
         OPC_ADDU: begin
            ctrl.use_adder = 1'b1;
            ctrl.rsel      = RSEL_SUM;
         end
         OPC_SUB: begin
            ctrl.invert_b   = 1'b1;
            ctrl.use_adder  = 1'b1;
            ctrl.report_ovf = 1'b1;
            ctrl.rsel       = RSEL_SUM;
         end
         OPC_SUBU: begin
            ctrl.invert_b  = 1'b1;
            ctrl.use_adder = 1'b1;
            ctrl.rsel      = RSEL_SUM;
         end
         OPC_AND: begin
            ctrl.rsel = RSEL_BITS;
            ctrl.bfn  = BFN_AND;
         end
         OPC_OR: begin
            ctrl.rsel = RSEL_BITS;
            ctrl.bfn  = BFN_OR;
         end
         OPC_NOR: begin
            ctrl.rsel = RSEL_BITS;
            ctrl.bfn  = BFN_NOR;
         end
         OPC_XOR: begin
            ctrl.rsel = RSEL_BITS;
            ctrl.bfn  = BFN_XOR;
         end
         OPC_SLT: begin
            ctrl.invert_b  = 1'b1;
            ctrl.use_adder = 1'b1;
            ctrl.rsel      = RSEL_LTS;
         end
         OPC_SLTU: begin
            ctrl.invert_b  = 1'b1;
            ctrl.use_adder = 1'b1;
            ctrl.rsel      = RSEL_LTU;
         end
         default: ;
      endcase
   end

   // R5/R10: only the two signed arithmetic codes may enable overflow reporting
   always_comb begin
      if (ctrl.report_ovf)
         p_ovf_enable_r5: assert (op == OPC_ADD || op == OPC_SUB)
            else $error("overflow enabled for op %0d", op);
   end

endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned STYLE = 0    // 0: explicit ripple chain, 1: split inferred adder
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             invert_b,
   output logic [WIDTH-1:0] sum,
   output logic             carry_msb_in,
   output logic             carry_out
);

   localparam int unsigned LOW_W = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("int_alu_adder: WIDTH must be at least 2");
   end
   if (STYLE > 1) begin : g_bad_style
      $error("int_alu_adder: STYLE must be 0 or 1");
   end

   logic [WIDTH-1:0] b_eff;
   logic             cin;

   assign b_eff = b ^ {WIDTH{invert_b}};
   assign cin   = invert_b;

   if (STYLE == 0) begin : g_ripple
      logic [WIDTH:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]   = a[i] ^ b_eff[i] ^ c[i];
         assign c[i+1]   = (a[i] & b_eff[i]) | (a[i] & c[i]) | (b_eff[i] & c[i]);
      end
      assign carry_msb_in = c[WIDTH-1];
      assign carry_out    = c[WIDTH];
   end else begin : g_split
      logic [WIDTH-1:0] low;
      assign low = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                 + {{LOW_W{1'b0}}, cin};
      assign carry_msb_in   = low[LOW_W];
      assign sum[LOW_W-1:0] = low[LOW_W-1:0];
      assign sum[WIDTH-1]   = a[WIDTH-1] ^ b_eff[WIDTH-1] ^ carry_msb_in;
      assign carry_out      = (a[WIDTH-1] & b_eff[WIDTH-1])
                            | (a[WIDTH-1] & carry_msb_in)
                            | (b_eff[WIDTH-1] & carry_msb_in);
   end

   // R1/R2: the carry chain agrees with plain wide arithmetic on the effective operand
   always_comb begin
      p_adder_sum_r1: assert ({carry_out, sum} ==
                              ({1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin}))
         else $error("adder mismatch");
   end

endmodule

// File: rtl/int_alu_bitwise.sv
module int_alu_bitwise
   import int_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  bfn_e             bfn,
   output logic [WIDTH-1:0] y
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      always_comb begin
         unique case (bfn)
            BFN_AND: y[i] = a[i] & b[i];
            BFN_OR:  y[i] = a[i] | b[i];
            BFN_NOR: y[i] = ~(a[i] | b[i]);
            BFN_XOR: y[i] = a[i] ^ b[i];
         endcase
      end
   end

endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned ADDER_STYLE = 0
) (
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   input  logic [OP_BITS-1:0] op,
   output logic [WIDTH-1:0]   result,
   output logic               zero,
   output logic               cout,
   output logic               ovf
);

   localparam int unsigned MSB = WIDTH - 1;

   alu_ctrl_t        ctrl;
   logic [WIDTH-1:0] sum;
   logic [WIDTH-1:0] bits;
   logic             c_msb;
   logic             c_top;
   logic             raw_ovf;
   logic             lt_signed;
   logic             lt_unsigned;

   int_alu_decode u_dec (
      .op   (op),
      .ctrl (ctrl)
   );

   int_alu_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_add (
      .a            (a),
      .b            (b),
      .invert_b     (ctrl.invert_b),
      .sum          (sum),
      .carry_msb_in (c_msb),
      .carry_out    (c_top)
   );

   int_alu_bitwise #(.WIDTH(WIDTH)) u_bits (
      .a   (a),
      .b   (b),
      .bfn (ctrl.bfn),
      .y   (bits)
   );

   assign raw_ovf     = c_msb ^ c_top;
   assign lt_signed   = sum[MSB] ^ raw_ovf;
   assign lt_unsigned = ~c_top;

   always_comb begin
      unique case (ctrl.rsel)
         RSEL_SUM:  result = sum;
         RSEL_BITS: result = bits;
         RSEL_LTS:  result = {{MSB{1'b0}}, lt_signed};
         RSEL_LTU:  result = {{MSB{1'b0}}, lt_unsigned};
         default:   result = '0;
      endcase
   end

   assign zero = ~|result;
   assign cout = ctrl.use_adder & c_top;
   assign ovf  = ctrl.report_ovf & raw_ovf;

   // R3/R4: a flagged signed add needs like-signed operands and a flipped sign
   always_comb begin
      if (ovf && op == OPC_ADD)
         p_no_overflow_r4: assert (a[MSB] == b[MSB] && result[MSB] != a[MSB])
            else $error("add overflow with mixed signs");
   end

   // R3/R4: a flagged signed subtract needs unlike-signed operands
   always_comb begin
      if (ovf && op == OPC_SUB)
         p_sub_overflow_r3: assert (a[MSB] != b[MSB] && result[MSB] != a[MSB])
            else $error("sub overflow with like signs");
   end

   // R6: bitwise codes clear both arithmetic flags
   always_comb begin
      if (ctrl.rsel == RSEL_BITS)
         p_logic_flags_r6: assert (!cout && !ovf)
            else $error("flags set on logic op");
   end

   // R7/R8: compare results occupy bit 0 only
   always_comb begin
      if (op == OPC_SLT || op == OPC_SLTU)
         p_set_shape_r7: assert (result[MSB:1] == '0 && !ovf)
            else $error("compare result malformed");
   end

   // R10: unused codes give an all-zero word and quiet flags
   always_comb begin
      if (op > OPC_SLTU)
         p_unused_quiet_r10: assert (zero && !cout && !ovf)
            else $error("unused op not quiet");
   end

endmodule

// File: tb/tb_int_alu.sv
module tb_int_alu;

   logic        clk = 1'b0;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic [3:0]  op = '0;
   logic [31:0] result;
   logic        zero;
   logic        cout;
   logic        ovf;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [31:0] res;
      logic        z;
      logic        c;
      logic        v;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   int_alu dut (
      .a(a), .b(b), .op(op),
      .result(result), .zero(zero), .cout(cout), .ovf(ovf)
   );

   function automatic exp_t model(input logic [3:0] o, input logic [31:0] x,
                                  input logic [31:0] y, input string req);
      exp_t e;
      logic [32:0] s;
      e.req = req;
      e.c = 1'b0;
      e.v = 1'b0;
      e.res = '0;
      case (o)
         4'd0, 4'd1: begin
            s = {1'b0, x} + {1'b0, y};
            e.res = s[31:0];
            e.c = s[32];
            if (o == 4'd0) e.v = (x[31] == y[31]) && (s[31] != x[31]);
         end
         4'd2, 4'd3, 4'd8, 4'd9: begin
            s = {1'b0, x} + {1'b0, ~y} + 33'd1;
            e.c = s[32];
            if (o == 4'd2) e.v = (x[31] != y[31]) && (s[31] != x[31]);
            if (o == 4'd8)      e.res = {31'd0, $signed(x) < $signed(y)};
            else if (o == 4'd9) e.res = {31'd0, x < y};
            else                e.res = s[31:0];
         end
         4'd4: e.res = x & y;
         4'd5: e.res = x | y;
         4'd6: e.res = ~(x | y);
         4'd7: e.res = x ^ y;
         default: e.res = '0;
      endcase
      e.z = (e.res == 32'd0);
      return e;
   endfunction

   task automatic drive(input logic [3:0] o, input logic [31:0] x,
                        input logic [31:0] y, input string req);
      @(negedge clk);
      op = o;
      a  = x;
      b  = y;
      sb.push_back(model(o, x, y, req));
   endtask

   // monitor: compares each applied vector at the following rising edge
   initial begin
      forever begin
         @(posedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (result !== e.res || zero !== e.z || cout !== e.c || ovf !== e.v) begin
               bad++;
               $display("FAIL %s op=%0d a=%h b=%h : got res=%h z=%b c=%b v=%b exp res=%h z=%b c=%b v=%b",
                        e.req, op, a, b, result, zero, cout, ovf, e.res, e.z, e.c, e.v);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 50000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // idle state: add of zeros
      drive(4'd0, 32'h0, 32'h0, "R9");
      // R1 add
      drive(4'd0, 32'd5, 32'd7, "R1");
      drive(4'd1, 32'hFFFF_FFFF, 32'd1, "R1");
      // R3 signed overflow both directions; zero and overflow together
      drive(4'd0, 32'h7FFF_FFFF, 32'd1, "R3");
      drive(4'd0, 32'h8000_0000, 32'h8000_0000, "R3");
      drive(4'd2, 32'h8000_0000, 32'd1, "R3");
      drive(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R3");
      // R4 no overflow for mixed-sign add or like-sign subtract
      drive(4'd0, 32'h7FFF_FFFF, 32'h8000_0000, "R4");
      drive(4'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R4");
      drive(4'd2, 32'h7FFF_FFFF, 32'd0, "R4");
      // R2 subtract and borrow
      drive(4'd2, 32'd3, 32'd9, "R2");
      drive(4'd3, 32'd9, 32'd3, "R2");
      // R9 equal compare via subtract
      drive(4'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R9");
      // R5 unsigned forms stay quiet
      drive(4'd1, 32'h7FFF_FFFF, 32'd1, "R5");
      drive(4'd3, 32'h8000_0000, 32'd1, "R5");
      drive(4'd9, 32'h8000_0000, 32'd1, "R5");
      drive(4'd8, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5");
      // R6 logic
      drive(4'd4, 32'hF0F0_1234, 32'hFF00_FFFF, "R6");
      drive(4'd5, 32'hF0F0_0000, 32'h0F0F_0001, "R6");
      drive(4'd6, 32'h0000_0000, 32'h0000_0000, "R6");
      drive(4'd7, 32'hAAAA_5555, 32'hFFFF_FFFF, "R6");
      // R7 signed compare, including overflowing difference
      drive(4'd8, 32'hFFFF_FFFF, 32'd1, "R7");
      drive(4'd8, 32'h8000_0000, 32'd1, "R7");
      drive(4'd8, 32'd1, 32'h8000_0000, "R7");
      drive(4'd8, 32'd4, 32'd4, "R7");
      // R8 unsigned compare
      drive(4'd9, 32'hFFFF_FFFF, 32'd1, "R8");
      drive(4'd9, 32'd1, 32'hFFFF_FFFF, "R8");
      drive(4'd9, 32'd6, 32'd6, "R8");
      // R10 unused codes
      for (int k = 10; k < 16; k++) drive(4'(k), 32'hFFFF_FFFF, 32'h1234_5678, "R10");
      // mixed patterns over every code
      for (int n = 0; n < 400; n++) begin
         logic [31:0] x;
         logic [31:0] y;
         x = $urandom;
         y = (n % 7 == 0) ? x : $urandom;
         drive(4'(n % 16), x, y, (n % 16 < 4) ? "R1" : (n % 16 < 8) ? "R6" : "R7");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule